// File: doc/BRIEF.md
# SPI ADC Channel Scan Sequencer

This block is the master side of a serial link to a multi-channel successive-approximation converter that answers two frames late. A start pulse launches a pass over the channels marked in an enable mask. Each enabled channel gets one 16-bit command frame, lowest channel first. Two extra frames follow to push the last conversions out of the converter. Every word that comes back from the third frame onward is matched to the command sent two frames earlier. It is checked against the channel tag in its top nibble, trimmed to the configured resolution, and presented with a one-cycle valid strobe and the channel number.

A single-channel mode reads one channel with exactly three frames. The same command is sent twice, and the third frame returns the sample. The block contains its own serial engine: clock divider, chip-select framing per frame, and mode-0 timing (clock idles low, data is launched on the falling edge and sampled on the rising edge, MSB first). A done pulse marks the end of a pass.

Top module: `adc_scan_seq`

## Requirements
- R1: A command frame is 16 bits: bit 12 = 1 (manual channel select), bit 11 = 1 (program request), bits 10:7 = channel number, bit 6 = range input latched at start, all other bits 0.
- R2: In scan mode, one command is sent for each set bit of `ch_mask`, in ascending channel order, and for no other channel.
- R3: A scan is made of (number of set mask bits + 2) frames; an all-zero mask gives exactly two frames and no result.
- R4: The word received in frame i (i >= 2) is reported with `res_ch` equal to the channel commanded in frame i-2; the words of frames 0 and 1 produce no result.
- R5: The last two frames of a scan, and the third frame of a single read, shift out an all-zero word on `mosi`.
- R6: `cs_n` is high between frames and after the last frame; `sclk` is low whenever `cs_n` is high; each frame has exactly 16 rising `sclk` edges.
- R7: With `single_mode` = 1, a pass is three frames: the command for `single_ch` twice, then the zero word; exactly one result is reported, tagged `single_ch`.
- R8: `res_err` is 1 when bits 15:12 of the received word differ from the expected channel, otherwise 0.
- R9: `res_data` equals bits 11 down to 12-DATA_BITS of the received word.
- R10: A `start` pulse while `busy` is 1 is ignored: the running pass is unchanged and no further pass follows it.
- R11: `done` is a one-cycle pulse after the final frame, with `busy` low in that cycle.
- R12: After reset `cs_n` = 1, `sclk` = 0, `busy` = 0, `done` = 0, `res_valid` = 0.
- R13: Each `sclk` phase (high or low) lasts HALF_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a pass when idle |
| single_mode | input | 1 | 1 = three-frame read of one channel |
| single_ch | input | 4 | Channel for single mode |
| ch_mask | input | NCH | Channel enable mask for scan mode |
| range_sel | input | 1 | Range bit copied into every command |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to converter |
| miso | input | 1 | Serial data from converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_ch | output | 4 | Channel of the result |
| res_data | output | DATA_BITS | Trimmed sample |
| res_err | output | 1 | Tag mismatch flag |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
A wrong remaining-channel mask or tag pipeline shows at once on the wire and on the result port: a skipped or repeated command is visible in the next frame's MOSI word, and a tag that slipped by one frame shows as `res_err` on the very next result, since the converter model returns each word with its own channel nibble. A frame counter that is off appears as a frame count other than enabled channels plus two, and as a done pulse one frame early or late. Divider or bit-counter faults show within the first frame as a wrong half-period or a rising-edge count other than 16.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int CMD_W = 16;
  localparam int CH_W  = 4;

  typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_GAP} eng_state_t;

  function automatic logic [CMD_W-1:0] build_cmd(input logic [CH_W-1:0] ch,
                                                 input logic rng);
    logic [CMD_W-1:0] w;
    w        = '0;
    w[12]    = 1'b1;
    w[11]    = 1'b1;
    w[10:7]  = ch;
    w[6]     = rng;
    return w;
  endfunction
endpackage

// File: rtl/adc_spi_engine.sv
module adc_spi_engine
  import adc_scan_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int HALF_DIV   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic [FRAME_BITS-1:0] tx_word,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi,
  input  logic                  miso,
  output logic [FRAME_BITS-1:0] rx_word,
  output logic                  frame_done
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS);

  eng_state_t            st;
  logic [CNT_W-1:0]      cnt;
  logic [BIT_W-1:0]      bitn;
  logic [FRAME_BITS-1:0] tx_sh;
  logic [FRAME_BITS-1:0] rx_sh;
  logic                  tick;

  assign tick = (cnt == CNT_W'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= E_IDLE;
      sclk       <= 1'b0;
      cs_n       <= 1'b1;
      mosi       <= 1'b0;
      cnt        <= '0;
      bitn       <= '0;
      tx_sh      <= '0;
      rx_sh      <= '0;
      rx_word    <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (st)
        E_IDLE: begin
          if (go) begin
            st    <= E_SHIFT;
            cs_n  <= 1'b0;
            mosi  <= tx_word[FRAME_BITS-1];
            tx_sh <= tx_word << 1;
            cnt   <= '0;
            bitn  <= '0;
          end
        end
        E_SHIFT: begin
          if (tick) begin
            cnt <= '0;
            if (!sclk) begin
              sclk  <= 1'b1;
              rx_sh <= {rx_sh[FRAME_BITS-2:0], miso};
            end else begin
              sclk <= 1'b0;
              if (bitn == BIT_W'(FRAME_BITS - 1)) begin
                cs_n    <= 1'b1;
                mosi    <= 1'b0;
                rx_word <= rx_sh;
                st      <= E_GAP;
              end else begin
                bitn  <= bitn + 1'b1;
                mosi  <= tx_sh[FRAME_BITS-1];
                tx_sh <= tx_sh << 1;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (tick) begin
            cnt        <= '0;
            frame_done <= 1'b1;
            st         <= E_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_ch_pick.sv
module adc_ch_pick
  import adc_scan_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic [NCH-1:0]  mask,
  output logic            found,
  output logic [CH_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/adc_res_unpack.sv
module adc_res_unpack
  import adc_scan_pkg::*;
#(
  parameter int DATA_BITS = 12
) (
  input  logic [CMD_W-1:0]     rx,
  input  logic [CH_W-1:0]      tag,
  output logic [DATA_BITS-1:0] data,
  output logic                 err
);
  localparam int TOP = CMD_W - CH_W - 1;

  assign data = rx[TOP -: DATA_BITS];
  assign err  = (rx[CMD_W-1 -: CH_W] != tag);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH       = 16,
  parameter int DATA_BITS = 12,
  parameter int HALF_DIV  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 single_mode,
  input  logic [CH_W-1:0]      single_ch,
  input  logic [NCH-1:0]       ch_mask,
  input  logic                 range_sel,
  output logic                 sclk,
  output logic                 cs_n,
  output logic                 mosi,
  input  logic                 miso,
  output logic                 res_valid,
  output logic [CH_W-1:0]      res_ch,
  output logic [DATA_BITS-1:0] res_data,
  output logic                 res_err,
  output logic                 busy,
  output logic                 done
);
  localparam int FW = $clog2(NCH + 3);

  logic [NCH-1:0]       rem;
  logic                 rep;
  logic                 range_q;
  logic [FW-1:0]        frames_left;
  logic [1:0]           seen;
  logic [CH_W-1:0]      cur_ch, tag1, tag2;
  logic                 go;
  logic [CMD_W-1:0]     tx_q;

  logic [NCH-1:0]       pick_src;
  logic                 rep_src, range_src, found;
  logic [CH_W-1:0]      pick_idx;
  logic [CMD_W-1:0]     rx_word;
  logic                 frame_done;
  logic [DATA_BITS-1:0] un_data;
  logic                 un_err;

  always_comb begin
    if (busy) begin
      pick_src  = rem;
      rep_src   = rep;
      range_src = range_q;
    end else begin
      pick_src  = single_mode ? (NCH'(1) << single_ch) : ch_mask;
      rep_src   = single_mode;
      range_src = range_sel;
    end
  end

  adc_ch_pick #(.NCH(NCH)) u_pick (
    .mask (pick_src),
    .found(found),
    .idx  (pick_idx)
  );

  adc_spi_engine #(.FRAME_BITS(CMD_W), .HALF_DIV(HALF_DIV)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .tx_word   (tx_q),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .miso      (miso),
    .rx_word   (rx_word),
    .frame_done(frame_done)
  );

  adc_res_unpack #(.DATA_BITS(DATA_BITS)) u_unpack (
    .rx  (rx_word),
    .tag (tag2),
    .data(un_data),
    .err (un_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem         <= '0;
      rep         <= 1'b0;
      range_q     <= 1'b0;
      frames_left <= '0;
      seen        <= '0;
      cur_ch      <= '0;
      tag1        <= '0;
      tag2        <= '0;
      go          <= 1'b0;
      tx_q        <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      res_valid   <= 1'b0;
      res_ch      <= '0;
      res_data    <= '0;
      res_err     <= 1'b0;
    end else begin
      go        <= 1'b0;
      done      <= 1'b0;
      res_valid <= 1'b0;
      if (!busy && start) begin
        busy        <= 1'b1;
        range_q     <= range_sel;
        seen        <= '0;
        frames_left <= single_mode ? FW'(3) : FW'($countones(ch_mask)) + FW'(2);
      end
      if (frame_done) begin
        tag1 <= cur_ch;
        tag2 <= tag1;
        if (seen == 2'd2) begin
          res_valid <= 1'b1;
          res_ch    <= tag2;
          res_data  <= un_data;
          res_err   <= un_err;
        end else begin
          seen <= seen + 1'b1;
        end
        if (frames_left == FW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          frames_left <= frames_left - 1'b1;
        end
      end
      if ((!busy && start) || (frame_done && frames_left != FW'(1))) begin
        go     <= 1'b1;
        tx_q   <= found ? build_cmd(pick_idx, range_src) : '0;
        cur_ch <= pick_idx;
        rem    <= rep_src ? pick_src : (pick_src & ~(NCH'(1) << pick_idx));
        rep    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sclk,
  input logic res_valid
);
  // R12: state after a reset cycle
  a_r12_reset_idle: assert property (@(posedge clk)
    rst |=> (cs_n && !sclk && !busy && !done && !res_valid));

  // R6: serial clock parked low while deselected
  a_r6_sclk_parked: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R6: no selection outside a pass
  a_r6_cs_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);

  // R11: done lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: done only when idle
  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10: a pass starts only from a start request
  a_r10_start_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R4: results appear only inside or at the end of a pass
  a_r4_valid_in_pass: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (busy || done));
endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .res_valid(res_valid)
);

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
  localparam int NCH = 16;
  localparam int DB  = 10;
  localparam int HD  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic single_mode = 1'b0;
  logic [3:0] single_ch = '0;
  logic [NCH-1:0] ch_mask = '0;
  logic range_sel = 1'b0;
  logic sclk, cs_n, mosi;
  logic miso = 1'b0;
  logic res_valid, res_err, busy, done;
  logic [3:0] res_ch;
  logic [DB-1:0] res_data;

  always #2.5 clk = ~clk;

  adc_scan_seq #(.NCH(NCH), .DATA_BITS(DB), .HALF_DIV(HD)) u0 (
    .clk(clk), .rst(rst), .start(start), .single_mode(single_mode),
    .single_ch(single_ch), .ch_mask(ch_mask), .range_sel(range_sel),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .res_valid(res_valid), .res_ch(res_ch), .res_data(res_data),
    .res_err(res_err), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // converter model
  logic [15:0] tx_log [32];
  int          rise_log [32];
  int          nfr = 0;
  int          corrupt_fr = -1;
  logic [11:0] salt = '0;
  logic [15:0] s_out, s_in;
  int          s_bit, s_rise;
  realtime     t_rise = 0, half_meas = 0;

  function automatic logic [11:0] val_of(input logic [3:0] ch, input logic [11:0] s);
    return 12'(ch * 12'd291 + s);
  endfunction

  always @(negedge cs_n) begin
    s_in = '0; s_bit = 0; s_rise = 0;
    if (nfr >= 2) begin
      logic [3:0] c;
      c = tx_log[nfr-2][10:7];
      s_out = {(nfr == corrupt_fr) ? (c ^ 4'h5) : c, val_of(c, salt)};
    end else begin
      s_out = 16'hA5A5;
    end
    miso = s_out[15];
  end
  always @(posedge sclk) begin
    s_in = {s_in[14:0], mosi}; s_rise++; t_rise = $realtime;
  end
  always @(negedge sclk) begin
    half_meas = $realtime - t_rise;
    s_bit++;
    if (s_bit < 16) miso = s_out[15 - s_bit];
  end
  always @(posedge cs_n) begin
    if (nfr < 32) begin tx_log[nfr] = s_in; rise_log[nfr] = s_rise; end
    nfr++;
  end

  // result monitor
  logic [3:0]    r_ch  [32];
  logic [DB-1:0] r_dat [32];
  logic          r_err [32];
  int nres = 0, ndone = 0;
  always @(negedge clk) begin
    cycles++;
    if (res_valid && nres < 32) begin
      r_ch[nres] = res_ch; r_dat[nres] = res_data; r_err[nres] = res_err; nres++;
    end
    if (done) begin
      ndone++;
      chk(busy == 1'b0, "R11", "busy at done", busy, 0);
    end
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] exp_cmd(input logic [3:0] ch, input logic rg);
    return {3'b000, 1'b1, 1'b1, ch, rg, 6'b0};
  endfunction

  task automatic run_pass(input logic [15:0] m, input bit sg, input logic [3:0] sc,
                          input bit rg, input int corrupt, input bit retrig);
    logic [3:0] ech [16];
    int ne = 0, nframes, nr, d0, w;
    for (int c = 0; c < NCH; c++) if (m[c]) begin ech[ne] = 4'(c); ne++; end
    if (sg) begin ech[0] = sc; ne = 1; end
    nframes = sg ? 3 : ne + 2;
    nr = ne;
    salt = 12'($urandom);
    corrupt_fr = corrupt;
    nfr = 0; nres = 0; d0 = ndone;
    @(negedge clk);
    ch_mask = m; single_mode = sg; single_ch = sc; range_sel = rg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (retrig) begin
      repeat (150) @(negedge clk);
      ch_mask = 16'hFFFF; single_mode = 1'b0; range_sel = ~rg; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (ndone == d0 && w < 20000) begin @(negedge clk); w++; end
    repeat (120) @(negedge clk);
    chk(ndone == d0 + 1, "R11", "done pulses", ndone - d0, 1);
    chk(nfr == nframes, "R3", "frame count", nfr, nframes);
    chk(busy == 1'b0 && cs_n == 1'b1, "R10", "idle after pass", {busy, cs_n}, 1);
    if (nfr == nframes) begin
      for (int k = 0; k < nframes; k++) begin
        logic [15:0] e;
        if (sg) e = (k < 2) ? exp_cmd(sc, rg) : 16'h0;
        else    e = (k < ne) ? exp_cmd(ech[k], rg) : 16'h0;
        if (sg) chk(tx_log[k] == e, "R7", "single cmd", tx_log[k], e);
        else if (k < ne) chk(tx_log[k] == e, "R1 R2", "cmd word", tx_log[k], e);
        else chk(tx_log[k] == e, "R5", "trailing word", tx_log[k], e);
        chk(rise_log[k] == 16, "R6", "rising edges", rise_log[k], 16);
      end
    end
    chk(nres == nr, sg ? "R7" : "R4", "result count", nres, nr);
    if (nres == nr) begin
      for (int i = 0; i < nr; i++) begin
        logic [11:0] v;
        bit ee;
        v = val_of(ech[i], salt);
        ee = (corrupt == i + 2);
        chk(r_ch[i] == ech[i], "R4", "result channel", r_ch[i], ech[i]);
        chk(r_dat[i] == v[11 -: DB], "R9", "result data", r_dat[i], v[11 -: DB]);
        chk(r_err[i] == ee, "R8", "tag error", r_err[i], ee);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R12 reset state, sampled while reset still held
    chk(cs_n == 1'b1 && sclk == 1'b0, "R12", "link idle", {cs_n, sclk}, 2);
    chk(busy == 1'b0 && done == 1'b0 && res_valid == 1'b0, "R12", "flags",
        {busy, done, res_valid}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    run_pass(16'h0001, 0, 0, 0, -1, 0);
    chk(half_meas == HD * 5.0, "R13", "sclk half period ps", int'(half_meas * 1000),
        int'(HD * 5000.0));
    run_pass(16'h8001, 0, 0, 1, -1, 0);
    run_pass(16'hFFFF, 0, 0, 1, -1, 0);
    run_pass(16'h0000, 0, 0, 0, -1, 0);          // R3: drain-only pass
    run_pass(16'h0000, 1, 4'd5, 1, -1, 0);       // R7
    run_pass(16'h0000, 1, 4'd15, 0, 2, 0);       // R7 with R8 mismatch
    run_pass(16'h0A5C, 0, 0, 0, 4, 0);           // R8 mid-scan mismatch
    run_pass(16'h0006, 0, 0, 1, -1, 1);          // R10 retrigger ignored
    for (int n = 0; n < 12; n++) begin
      logic [15:0] m;
      m = 16'($urandom);
      run_pass(m, 0, 0, 1'($urandom), ($urandom % 3 == 0) ? 2 + int'($urandom % 3) : -1, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule